// File: doc/BRIEF.md
# Multiplexed Bus Turnaround Sequencer

This block runs single transactions on a local bus whose address and data share one set of lines, with an external bidirectional transceiver between the block and the devices. A requester hands over one command at a time: read, write or read-modify-write. Each command carries an address, write data, a port size and a count of extra idle cycles. The block then produces the lane drive value and output enable, a one-cycle address latch strobe and the transceiver direction line. It samples read data and returns the result with a done pulse.

Contention is prevented by one flag that records whether the bus was left floating. Whenever a new address phase would start on a floating bus, exactly one turnaround cycle comes first. After a write the block keeps driving the lanes while idle, so the next address phase starts at once. After a read the direction line stays low through the programmable idle cycles. It then returns high while the lanes stay released.

Top module: `busTurnSeq`

## Requirements
- R1: An address phase lasts one cycle. In it `addrLatch` is high, `busOe` is high, `busOut` carries the address and `xcvrDir` is high. `addrLatch` is never high in two consecutive cycles.
- R2: The cycle after a read's address phase is the read data cycle. In it `xcvrDir` is low and `busOe` is low. `busIn` is sampled at the end of that cycle.
- R3: After the read data cycle, the block adds the number of idle cycles given by `extraIdle`, as captured when the request is accepted (0 to 15). In each of these cycles `xcvrDir` is low and `busOe` is low.
- R4: When a read finishes, `xcvrDir` goes high and `busOe` stays low. Any address phase that starts while the bus is floating is preceded by exactly one turnaround cycle, in which `busOe` is low, `xcvrDir` is high and `addrLatch` is low.
- R5: A write's address phase is followed by one data cycle that drives the write data. After that the lanes stay driven with that value while idle. The next address phase then follows acceptance directly, with no turnaround cycle.
- R6: A read-modify-write runs the full read sequence, then one turnaround cycle, a new address phase with the same address, and one write data cycle. Its done pulse carries the value read.
- R7: `reqWide`=1 selects a 16-bit port on lanes 0 to 15. `reqWide`=0 selects an 8-bit port on lanes 0 to 7. For an 8-bit port, write data lanes 8 to 15 are driven as zero and read lanes 8 to 15 are ignored, so they return as zero.
- R8: After reset the bus is released, `xcvrDir` is high, `addrLatch` and `donePulse` are low and `reqReady` is high. The first address phase after reset is preceded by a turnaround cycle.
- R9: A request is accepted only on a clock edge where `reqValid` and `reqReady` are both high. `reqReady` is high only while the sequencer is idle. `reqValid` while busy has no effect.
- R10: `donePulse` is high for one cycle, the cycle after the final phase cycle. `doneData` then holds the read value for reads and read-modify-writes, and zero for writes. `doneData` is zero whenever `donePulse` is low.
- R11: `reqOp` encoding: 2'b00 read, 2'b01 write, 2'b10 read-modify-write, 2'b11 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| reqOp | input | 2 | Command code (see R11) |
| reqAddr | input | 16 | Address driven in the address phase |
| reqWdata | input | 16 | Write data |
| reqWide | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| extraIdle | input | 4 | Extra idle cycles after read sampling |
| busOut | output | 16 | Value driven on the shared lanes |
| busOe | output | 1 | Lane drive enable |
| busIn | input | 16 | Value seen on the shared lanes |
| addrLatch | output | 1 | Address latch strobe |
| xcvrDir | output | 1 | Transceiver direction, high = outbound |
| donePulse | output | 1 | Transaction complete |
| doneData | output | 16 | Read result while donePulse is high |

## Verification
Counting from the accepting edge, the first cycle is a turnaround cycle when the bus was floating and the address phase otherwise. A write's data cycle follows the address phase by one cycle. A read holds the lanes released for 1 + `extraIdle` cycles, and the done pulse comes in the cycle after the last phase cycle. The bench model builds, at each acceptance, the list of expected per-cycle output values from these counts. It compares that list with every port at each falling edge, where all outputs are already settled from the preceding rising edge.

// File: rtl/busTurnSeqPkg.sv
package busTurnSeqPkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_WRITE   = 2'b01,
    OP_RMW     = 2'b10,
    OP_READ_ALT= 2'b11
  } seqOpE;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TURN,
    S_ADDR,
    S_WDATA,
    S_RDATA,
    S_HOLD
  } seqStateE;

  typedef struct packed {
    logic load;     // take a new request
    logic capture;  // sample read lanes
    logic selAddr;  // drive address instead of data
    logic done;     // present result
  } seqStrobeT;

endpackage

// File: rtl/busTurnSeqCtrl.sv
module busTurnSeqCtrl
  import busTurnSeqPkg::*;
#(
  parameter int IDLE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [IDLE_W-1:0] extraIdle,
  output logic              reqReady,
  output logic              busOe,
  output logic              addrLatch,
  output logic              xcvrDir,
  output logic              donePulse,
  output seqStrobeT         strobes
);

  seqStateE          state;
  seqStateE          stateNext;
  logic              floatQ;
  logic              writeLegQ;
  logic              rmwQ;
  logic              doneQ;
  logic [IDLE_W-1:0] idleQ;
  logic [IDLE_W-1:0] holdCnt;
  logic              accept;
  logic              readEnd;

  assign accept  = reqValid && (state == S_IDLE);
  assign readEnd = ((state == S_RDATA) && (idleQ == '0)) ||
                   ((state == S_HOLD)  && (holdCnt == '0));

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (accept) stateNext = floatQ ? S_TURN : S_ADDR;
      S_TURN:  stateNext = S_ADDR;
      S_ADDR:  stateNext = writeLegQ ? S_WDATA : S_RDATA;
      S_WDATA: stateNext = S_IDLE;
      S_RDATA: stateNext = readEnd ? (rmwQ ? S_TURN : S_IDLE) : S_HOLD;
      S_HOLD:  if (readEnd) stateNext = rmwQ ? S_TURN : S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      floatQ    <= 1'b1;
      writeLegQ <= 1'b0;
      rmwQ      <= 1'b0;
      doneQ     <= 1'b0;
      idleQ     <= '0;
      holdCnt   <= '0;
    end else begin
      state <= stateNext;
      doneQ <= 1'b0;
      if (accept) begin
        writeLegQ <= (seqOpE'(reqOp) == OP_WRITE);
        rmwQ      <= (seqOpE'(reqOp) == OP_RMW);
        idleQ     <= extraIdle;
      end
      if (state == S_RDATA && !readEnd) holdCnt <= idleQ - IDLE_W'(1);
      if (state == S_HOLD && !readEnd)  holdCnt <= holdCnt - IDLE_W'(1);
      if (readEnd) begin
        floatQ <= 1'b1;
        if (rmwQ) writeLegQ <= 1'b1;
        else      doneQ     <= 1'b1;
      end
      if (state == S_WDATA) begin
        floatQ <= 1'b0;
        doneQ  <= 1'b1;
      end
    end
  end

  assign reqReady  = (state == S_IDLE);
  assign addrLatch = (state == S_ADDR);
  assign xcvrDir   = !((state == S_RDATA) || (state == S_HOLD));
  assign busOe     = (state == S_ADDR) || (state == S_WDATA) ||
                     ((state == S_IDLE) && !floatQ);
  assign donePulse = doneQ;

  assign strobes.load    = accept;
  assign strobes.capture = (state == S_RDATA);
  assign strobes.selAddr = (state == S_ADDR);
  assign strobes.done    = doneQ;

  // R1: the latch strobe lasts a single cycle
  p_ale_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    addrLatch |=> !addrLatch);

  // R2: the cycle after a read address phase releases the lanes, direction inbound
  p_read_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addrLatch && !writeLegQ) |=> (!busOe && !xcvrDir));

  // R4: direction returning outbound never coincides with driving the lanes
  p_dir_turn_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xcvrDir) |-> !busOe);

  // R4: every address phase is preceded by driving lanes or a turnaround cycle
  p_turn_before_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR) |-> ($past(busOe) || ($past(state) == S_TURN)));

  // R5: a turnaround cycle only follows a released bus
  p_no_turn_after_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TURN) |-> $past(!busOe));

  // R9: once a request is taken, the sequencer reports busy
  p_ready_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R10: completion is a one-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

endmodule

// File: rtl/busTurnSeqDatapath.sv
module busTurnSeqDatapath
  import busTurnSeqPkg::*;
#(
  parameter int BUS_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobeT        strobes,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic             reqWide,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic [BUS_W-1:0] doneData
);

  logic [BUS_W-1:0] addrQ;
  logic [BUS_W-1:0] wdataQ;
  logic [BUS_W-1:0] capQ;
  logic             wideQ;
  logic [BUS_W-1:0] reqMask;
  logic [BUS_W-1:0] laneMask;

  for (genvar lane = 0; lane < BUS_W; lane++) begin : g_lane
    if (lane < NARROW_W) begin : g_low
      assign reqMask[lane]  = 1'b1;
      assign laneMask[lane] = 1'b1;
    end else begin : g_high
      assign reqMask[lane]  = reqWide;
      assign laneMask[lane] = wideQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      capQ   <= '0;
      wideQ  <= 1'b1;
    end else begin
      if (strobes.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata & reqMask;
        wideQ  <= reqWide;
        capQ   <= '0;
      end
      if (strobes.capture) capQ <= busIn & laneMask;
    end
  end

  assign busOut   = strobes.selAddr ? addrQ : wdataQ;
  assign doneData = strobes.done ? capQ : '0;

endmodule

// File: rtl/busTurnSeq.sv
module busTurnSeq
  import busTurnSeqPkg::*;
#(
  parameter int BUS_W    = 16,
  parameter int NARROW_W = 8,
  parameter int IDLE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [BUS_W-1:0]  reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  input  logic              reqWide,
  input  logic [IDLE_W-1:0] extraIdle,
  output logic [BUS_W-1:0]  busOut,
  output logic              busOe,
  input  logic [BUS_W-1:0]  busIn,
  output logic              addrLatch,
  output logic              xcvrDir,
  output logic              donePulse,
  output logic [BUS_W-1:0]  doneData
);

  seqStrobeT strobes;

  busTurnSeqCtrl #(.IDLE_W(IDLE_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .extraIdle (extraIdle),
    .reqReady  (reqReady),
    .busOe     (busOe),
    .addrLatch (addrLatch),
    .xcvrDir   (xcvrDir),
    .donePulse (donePulse),
    .strobes   (strobes)
  );

  busTurnSeqDatapath #(.BUS_W(BUS_W), .NARROW_W(NARROW_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqWide  (reqWide),
    .busIn    (busIn),
    .busOut   (busOut),
    .doneData (doneData)
  );

endmodule

// File: tb/busTurnSeq_test.sv
module busTurnSeq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'b00;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqWide = 1'b1;
  logic [3:0]  extraIdle = '0;
  logic [15:0] busOut;
  logic        busOe;
  logic [15:0] busIn = '0;
  logic        addrLatch;
  logic        xcvrDir;
  logic        donePulse;
  logic [15:0] doneData;

  always #(CLK_PERIOD/2) clk = ~clk;

  busTurnSeq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqWide(reqWide),
    .extraIdle(extraIdle), .busOut(busOut), .busOe(busOe), .busIn(busIn),
    .addrLatch(addrLatch), .xcvrDir(xcvrDir), .donePulse(donePulse),
    .doneData(doneData)
  );

  typedef struct {
    bit          oe;
    logic [15:0] out;
    bit          ale;
    bit          dir;
    bit          ready;
    bit          done;
    logic [15:0] data;
    string       tag;
  } expT;

  typedef struct {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [15:0] wd;
    bit          wide;
    logic [3:0]  idle;
    logic [15:0] rd;
  } txnT;

  expT  expQ[$];
  txnT  stim[$];
  int   checks = 0;
  int   errors = 0;
  bit   modelFloat = 1'b1;
  bit   parkOe = 1'b0;
  logic [15:0] parkOut = '0;

  task automatic check(bit ok, string tag, string field, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, field, act, exp);
    end
  endtask

  function automatic void pushCyc(bit oe, logic [15:0] out, bit ale, bit dir, string tag);
    expT e;
    e.oe = oe; e.out = out; e.ale = ale; e.dir = dir;
    e.ready = 1'b0; e.done = 1'b0; e.data = '0; e.tag = tag;
    expQ.push_back(e);
  endfunction

  function automatic expT idleCyc(bit done, logic [15:0] data, string tag);
    expT e;
    e.oe = parkOe; e.out = parkOut; e.ale = 1'b0; e.dir = 1'b1;
    e.ready = 1'b1; e.done = done; e.data = data; e.tag = tag;
    return e;
  endfunction

  // behavioural model: expected outputs of each cycle after the accepting edge
  function automatic void modelAccept(txnT t);
    logic [15:0] mask;
    mask = t.wide ? 16'hffff : 16'h00ff;
    if (modelFloat) pushCyc(1'b0, '0, 1'b0, 1'b1, "R4 turnaround");
    pushCyc(1'b1, t.addr, 1'b1, 1'b1, "R1 address phase");
    if (t.op == 2'b01) begin
      pushCyc(1'b1, t.wd & mask, 1'b0, 1'b1, "R5 write data");
      parkOe = 1'b1; parkOut = t.wd & mask; modelFloat = 1'b0;
      expQ.push_back(idleCyc(1'b1, '0, "R10 write done"));
    end else begin
      pushCyc(1'b0, '0, 1'b0, 1'b0, "R2 read data");
      for (int i = 0; i < t.idle; i++) pushCyc(1'b0, '0, 1'b0, 1'b0, "R3 extra idle");
      if (t.op == 2'b10) begin
        pushCyc(1'b0, '0, 1'b0, 1'b1, "R6 turnaround");
        pushCyc(1'b1, t.addr, 1'b1, 1'b1, "R6 address phase");
        pushCyc(1'b1, t.wd & mask, 1'b0, 1'b1, "R6 write data");
        parkOe = 1'b1; parkOut = t.wd & mask; modelFloat = 1'b0;
      end else begin
        parkOe = 1'b0; modelFloat = 1'b1;
      end
      expQ.push_back(idleCyc(1'b1, t.rd & mask, "R10 R7 read done"));
    end
  endfunction

  function automatic void addTxn(logic [1:0] op, logic [15:0] addr, logic [15:0] wd,
                                 bit wide, logic [3:0] idle, logic [15:0] rd);
    txnT t;
    t.op = op; t.addr = addr; t.wd = wd; t.wide = wide; t.idle = idle; t.rd = rd;
    stim.push_back(t);
  endfunction

  initial begin
    expT e;
    int  cyc;
    int  tail;
    bit  fin;
    // R11 codes: 00 read, 01 write, 10 read-modify-write, 11 read
    addTxn(2'b00, 16'h1234, 16'h0000, 1'b1, 4'd0, 16'hA5C3); // R8 first gets turnaround
    addTxn(2'b00, 16'h0042, 16'h0000, 1'b0, 4'd3, 16'hBEEF); // R7 narrow read, R3
    addTxn(2'b01, 16'h2000, 16'h1357, 1'b1, 4'd0, 16'h0000); // R4 after read
    addTxn(2'b01, 16'h2002, 16'hABCD, 1'b0, 4'd0, 16'h0000); // R5 no turnaround, R7
    addTxn(2'b00, 16'h3000, 16'h0000, 1'b1, 4'd2, 16'h0F0F); // R5 read after write
    addTxn(2'b10, 16'h4000, 16'h5555, 1'b1, 4'd1, 16'h7E81); // R6
    addTxn(2'b11, 16'h5000, 16'h0000, 1'b0, 4'd0, 16'h99AA); // R11 alt read code
    addTxn(2'b10, 16'h6000, 16'hFFFF, 1'b0, 4'd0, 16'h1122); // R6 narrow
    addTxn(2'b01, 16'h7000, 16'h8001, 1'b1, 4'd2, 16'h0000); // write, idle ignored
    addTxn(2'b10, 16'h8000, 16'h0246, 1'b1, 4'd15, 16'h3C3C); // R3 max idle, R6

    repeat (3) @(negedge clk);
    e = idleCyc(1'b0, '0, "R8 in reset");
    check(busOe == 1'b0 && xcvrDir == 1'b1 && addrLatch == 1'b0 && donePulse == 1'b0,
          e.tag, "oe/dir/ale/done", {12'h0, busOe, xcvrDir, addrLatch, donePulse}, 16'h0004);
    rstN = 1'b1;

    cyc = 0; tail = 0; fin = 1'b0;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      if (expQ.size() > 0) e = expQ.pop_front();
      else e = idleCyc(1'b0, '0, "R8 R9 idle");
      check(busOe == e.oe, e.tag, "busOe", {15'h0, busOe}, {15'h0, e.oe});
      if (e.oe) check(busOut == e.out, e.tag, "busOut", busOut, e.out);
      check(addrLatch == e.ale, e.tag, "addrLatch", {15'h0, addrLatch}, {15'h0, e.ale});
      check(xcvrDir == e.dir, e.tag, "xcvrDir", {15'h0, xcvrDir}, {15'h0, e.dir});
      check(reqReady == e.ready, {e.tag, " R9"}, "reqReady", {15'h0, reqReady}, {15'h0, e.ready});
      check(donePulse == e.done, {e.tag, " R10"}, "donePulse", {15'h0, donePulse}, {15'h0, e.done});
      check(doneData == e.data, {e.tag, " R10"}, "doneData", doneData, e.data);
      // drive inputs for the coming edge
      if (e.ready && stim.size() > 0) begin
        txnT t;
        t = stim.pop_front();
        reqValid = 1'b1; reqOp = t.op; reqAddr = t.addr; reqWdata = t.wd;
        reqWide = t.wide; extraIdle = t.idle;
        busIn = t.wide ? t.rd : {8'hC7, t.rd[7:0]};
        if (!t.wide) busIn[15:8] = t.rd[15:8] ^ 8'hFF; // R7 upper lanes must be ignored
        modelAccept(t);
      end else if (!e.ready) begin
        // R9 requests while busy are ignored
        reqValid = 1'b1; reqOp = 2'b01; reqAddr = 16'hDEAD; reqWdata = 16'hF00D;
        reqWide = 1'b1; extraIdle = 4'd9;
      end else begin
        reqValid = 1'b0;
        tail++;
        if (tail > 4) fin = 1'b1;
      end
      if (cyc > 5000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 5000);
        fin = 1'b1;
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule